// File: doc/BRIEF.md
# SPI Buffer Transfer Sequencer

This block moves characters between a memory buffer and the data registers of an SPI controller with no processor involvement. Each direction has a channel: a current pointer and a remaining count, plus a queued next pointer and next count. When the SPI reports that its transmit holding register is free, the transmit channel reads one character from memory and hands it over. When the SPI reports that a received character is waiting, the receive channel takes it and writes it to memory. Every character costs exactly one memory access on a single shared memory port. The SPI's own empty and ready flags are used only inside the block. What software sees is the end-of-buffer state and the buffer-empty or buffer-full state of each direction.

The size of each memory access and the pointer step depend on two settings: the peripheral-selection mode and the character width. In fixed mode every character goes to one peripheral, whose chip-select code comes from a configuration input. The buffer then holds bytes for 8-bit characters and halfwords for 9- to 16-bit characters. In variable mode each buffer entry is a 32-bit word that carries, next to the character, a chip-select code and an end-of-transfer marker. Consecutive characters can therefore address different peripherals. In both modes the number of bits shifted on the wire stays 8 to 16 and is set by the width setting. When a buffer runs out and a next buffer is queued, the channel moves on to it in the same clock edge.

Top module: `spi_buf_seq`

## Requirements
- R1: After reset all eight channel registers read zero, all four status outputs (tx_end, tx_empty, rx_end, rx_full) are 1, and no memory access or SPI handshake is issued.
- R2: A transmit transfer happens in a cycle where spi_tx_empty is 1 and the transmit count is nonzero. In that cycle spi_tx_load, mem_req and a memory read (mem_we=0) are all active. A receive transfer happens in a cycle where spi_rx_ready is 1 and the receive count is nonzero. In that cycle spi_rx_take, mem_req and a memory write (mem_we=1) are all active. Exactly one access is made per character.
- R3: In fixed mode (cfg_var_mode=0) with widths up to 8 bits, each transfer is a byte access (mem_size=0) at the current pointer. After the transfer the pointer has grown by 1 and the count has dropped by 1. Memory data is right-justified.
- R4: In fixed mode with 9 to 16 bits, each transfer is a halfword access (mem_size=1), the pointer grows by 2 and the count drops by 1. Character bits above the configured width are zero on spi_tx_data and in mem_wdata, and mem_wdata[31:16] is zero.
- R5: In variable mode (cfg_var_mode=1), each transfer is a word access (mem_size=2), the pointer grows by 4 and the count drops by 1, for every character width.
- R6: The variable-mode word holds the character in bits 15:0 (masked to the width), the chip-select code in bits 23:16, and the end-of-transfer marker in bits 31:24 (any nonzero value means last). A receive write places the received character and the received chip-select in those fields and zeros bits 31:24. In fixed mode spi_tx_cs is cfg_fixed_cs and spi_tx_last is 0.
- R7: tx_end or rx_end is 1 exactly when that channel's current count is zero. tx_empty or rx_full is 1 exactly when both its current and its next count are zero.
- R8: When a channel's count is zero, or reaches zero through a transfer, and its next count is nonzero, then at that same edge the next pointer and next count load into the current ones and the next count clears. This does not happen in a cycle where software writes a register of that channel.
- R9: The two channels keep separate registers. When both request in the same cycle, the receive transfer is served and the transmit transfer waits for a later cycle.
- R10: The register port selects with reg_sel (bit 2: 0 transmit, 1 receive; bits 1:0: 0 pointer, 1 count, 2 next pointer, 3 next count). reg_rdata returns the selected register. A write takes effect at the next edge and wins over a transfer update of the same register.
- R11: A channel whose count is zero makes no transfer while its SPI flag is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_var_mode | input | 1 | 1 selects variable peripheral mode |
| cfg_char_bits | input | 5 | Character width, 8 to 16 (clamped) |
| cfg_fixed_cs | input | 8 | Chip-select code used in fixed mode |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Selected register value |
| spi_tx_empty | input | 1 | SPI transmit holding register free |
| spi_tx_load | output | 1 | Character presented to SPI this cycle |
| spi_tx_data | output | 16 | Transmit character |
| spi_tx_cs | output | 8 | Chip-select code for the character |
| spi_tx_last | output | 1 | End-of-transfer marker for the character |
| spi_rx_ready | input | 1 | SPI holds a received character |
| spi_rx_data | input | 16 | Received character |
| spi_rx_cs | input | 8 | Chip-select code of the received character |
| spi_rx_take | output | 1 | Received character consumed this cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Right-justified write data |
| mem_rdata | input | 32 | Right-justified read data, same cycle |
| tx_end | output | 1 | Transmit count is zero |
| tx_empty | output | 1 | Transmit count and next count are zero |
| rx_end | output | 1 | Receive count is zero |
| rx_full | output | 1 | Receive count and next count are zero |

## Verification
The transmit path is run with 8-bit fixed, 12-bit fixed and 10-bit variable settings. Each gives a different access size and step, so a wrong size choice, a wrong step or a missing width mask shows up as a wrong address or wrong data. The receive path is run with all-ones data at 9 bits, which shows whether upper bits are zero-filled, and with a variable-mode character and chip-select, which shows whether the fields land in the right place. Buffer chaining is tried both at the end of a transfer and from an idle channel. Other patterns cover simultaneous requests, a zero count with active flags, and a register write that collides with a transfer.

// File: rtl/spi_buf_seq_pkg.sv
`timescale 1ns/1ps
package spi_buf_seq_pkg;
  localparam int WORD_W   = 32;
  localparam int CHAR_W   = 16;
  localparam int CS_LSB   = 16;
  localparam int FLAG_LSB = 24;
  localparam int CS_W     = FLAG_LSB - CS_LSB;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    F_PTR  = 2'd0,
    F_CNT  = 2'd1,
    F_NPTR = 2'd2,
    F_NCNT = 2'd3
  } reg_field_e;

  // Width setting limited to the legal 8..16 range.
  function automatic logic [4:0] clamp_bits(input logic [4:0] b);
    if (b < 5'd8)  return 5'd8;
    if (b > 5'd16) return 5'd16;
    return b;
  endfunction

  // Memory access size for the mode and width.
  function automatic acc_size_e pick_size(input logic var_mode, input logic [4:0] b);
    if (var_mode)                  return SZ_WORD;
    if (clamp_bits(b) == 5'd8)     return SZ_BYTE;
    return SZ_HALF;
  endfunction

  // Pointer increment in bytes for an access size.
  function automatic logic [2:0] step_bytes(input acc_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Ones in the low bits that carry the character.
  function automatic logic [CHAR_W-1:0] char_mask(input logic [4:0] b);
    logic [CHAR_W:0] m;
    m = ({{CHAR_W{1'b0}}, 1'b1} << clamp_bits(b)) - 1'b1;
    return m[CHAR_W-1:0];
  endfunction
endpackage

// File: rtl/spi_buf_chan.sv
`timescale 1ns/1ps
module spi_buf_chan #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        wr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              go,
  input  logic [2:0]        step,
  output logic [ADDR_W-1:0] ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] nptr,
  output logic [CNT_W-1:0]  ncnt,
  output logic              reload,
  output logic              active,
  output logic              end_flag,
  output logic              done_flag
);
  import spi_buf_seq_pkg::*;

  logic              any_wr;
  logic [CNT_W-1:0]  cnt_after;
  logic [ADDR_W-1:0] ptr_after;

  assign any_wr    = |wr;
  assign cnt_after = go ? cnt - CNT_W'(1) : cnt;
  assign ptr_after = go ? ptr + ADDR_W'(step) : ptr;
  assign reload    = !any_wr && (cnt_after == '0) && (ncnt != '0);
  assign active    = (cnt != '0);
  assign end_flag  = (cnt == '0);
  assign done_flag = (cnt == '0) && (ncnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      cnt  <= '0;
      nptr <= '0;
      ncnt <= '0;
    end else begin
      if (wr[F_PTR])      ptr <= wdata;
      else if (reload)    ptr <= nptr;
      else                ptr <= ptr_after;

      if (wr[F_CNT])      cnt <= wdata[CNT_W-1:0];
      else if (reload)    cnt <= ncnt;
      else                cnt <= cnt_after;

      if (wr[F_NPTR])     nptr <= wdata;

      if (wr[F_NCNT])     ncnt <= wdata[CNT_W-1:0];
      else if (reload)    ncnt <= '0;
    end
  end
endmodule

// File: rtl/spi_buf_pack.sv
`timescale 1ns/1ps
module spi_buf_pack
  import spi_buf_seq_pkg::*;
(
  input  logic              var_mode,
  input  logic [4:0]        char_bits,
  input  logic [CS_W-1:0]   fixed_cs,
  input  logic [WORD_W-1:0] rd_word,
  output logic [CHAR_W-1:0] tx_data,
  output logic [CS_W-1:0]   tx_cs,
  output logic              tx_last,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic [CS_W-1:0]   rx_cs,
  output logic [WORD_W-1:0] wr_word
);
  logic [CHAR_W-1:0] mask;

  assign mask    = char_mask(char_bits);
  assign tx_data = rd_word[CHAR_W-1:0] & mask;
  assign tx_cs   = var_mode ? rd_word[CS_LSB +: CS_W] : fixed_cs;
  assign tx_last = var_mode & (|rd_word[WORD_W-1:FLAG_LSB]);

  always_comb begin
    wr_word = '0;
    wr_word[CHAR_W-1:0] = rx_data & mask;
    if (var_mode) wr_word[CS_LSB +: CS_W] = rx_cs;
  end
endmodule

// File: rtl/spi_buf_seq.sv
`timescale 1ns/1ps
module spi_buf_seq
  import spi_buf_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_var_mode,
  input  logic [4:0]        cfg_char_bits,
  input  logic [CS_W-1:0]   cfg_fixed_cs,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              spi_tx_empty,
  output logic              spi_tx_load,
  output logic [CHAR_W-1:0] spi_tx_data,
  output logic [CS_W-1:0]   spi_tx_cs,
  output logic              spi_tx_last,
  input  logic              spi_rx_ready,
  input  logic [CHAR_W-1:0] spi_rx_data,
  input  logic [CS_W-1:0]   spi_rx_cs,
  output logic              spi_rx_take,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_end,
  output logic              tx_empty,
  output logic              rx_end,
  output logic              rx_full
);
  localparam int NCH = 2;
  localparam int TXC = 0;
  localparam int RXC = 1;

  logic [3:0]        ch_wr     [NCH];
  logic              ch_go     [NCH];
  logic [ADDR_W-1:0] ch_ptr    [NCH];
  logic [CNT_W-1:0]  ch_cnt    [NCH];
  logic [ADDR_W-1:0] ch_nptr   [NCH];
  logic [CNT_W-1:0]  ch_ncnt   [NCH];
  logic              ch_reload [NCH];
  logic              ch_active [NCH];
  logic              ch_end    [NCH];
  logic              ch_done   [NCH];

  acc_size_e         cur_size;
  logic [2:0]        cur_step;
  logic              tx_go, rx_go;
  logic [WORD_W-1:0] rx_word;

  // Named internal events for the checker.
  logic [ADDR_W-1:0] tx_ptr;
  logic [CNT_W-1:0]  tx_cnt, tx_ncnt;
  logic              tx_reload, tx_wr_any;

  assign cur_size = pick_size(cfg_var_mode, cfg_char_bits);
  assign cur_step = step_bytes(cur_size);

  // Receive wins the shared memory port.
  assign rx_go = spi_rx_ready && ch_active[RXC];
  assign tx_go = spi_tx_empty && ch_active[TXC] && !rx_go;
  assign ch_go[TXC] = tx_go;
  assign ch_go[RXC] = rx_go;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ch_wr[c] = '0;
      if (reg_wr && (reg_sel[2] == 1'(c))) ch_wr[c][reg_sel[1:0]] = 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    spi_buf_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ch_wr[c]),
      .wdata    (reg_wdata),
      .go       (ch_go[c]),
      .step     (cur_step),
      .ptr      (ch_ptr[c]),
      .cnt      (ch_cnt[c]),
      .nptr     (ch_nptr[c]),
      .ncnt     (ch_ncnt[c]),
      .reload   (ch_reload[c]),
      .active   (ch_active[c]),
      .end_flag (ch_end[c]),
      .done_flag(ch_done[c])
    );
  end

  spi_buf_pack u_pack (
    .var_mode (cfg_var_mode),
    .char_bits(cfg_char_bits),
    .fixed_cs (cfg_fixed_cs),
    .rd_word  (mem_rdata),
    .tx_data  (spi_tx_data),
    .tx_cs    (spi_tx_cs),
    .tx_last  (spi_tx_last),
    .rx_data  (spi_rx_data),
    .rx_cs    (spi_rx_cs),
    .wr_word  (rx_word)
  );

  assign mem_req     = tx_go || rx_go;
  assign mem_we      = rx_go;
  assign mem_size    = cur_size;
  assign mem_addr    = rx_go ? ch_ptr[RXC] : ch_ptr[TXC];
  assign mem_wdata   = rx_word;
  assign spi_tx_load = tx_go;
  assign spi_rx_take = rx_go;

  always_comb begin
    case (reg_field_e'(reg_sel[1:0]))
      F_PTR:   reg_rdata = ch_ptr[reg_sel[2]];
      F_CNT:   reg_rdata = ADDR_W'(ch_cnt[reg_sel[2]]);
      F_NPTR:  reg_rdata = ch_nptr[reg_sel[2]];
      default: reg_rdata = ADDR_W'(ch_ncnt[reg_sel[2]]);
    endcase
  end

  assign tx_end   = ch_end[TXC];
  assign tx_empty = ch_done[TXC];
  assign rx_end   = ch_end[RXC];
  assign rx_full  = ch_done[RXC];

  assign tx_ptr    = ch_ptr[TXC];
  assign tx_cnt    = ch_cnt[TXC];
  assign tx_ncnt   = ch_ncnt[TXC];
  assign tx_reload = ch_reload[TXC];
  assign tx_wr_any = |ch_wr[TXC];
endmodule

// File: rtl/spi_buf_seq_chk.sv
`timescale 1ns/1ps
module spi_buf_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_var_mode,
  input logic              spi_tx_load,
  input logic              spi_rx_take,
  input logic              mem_req,
  input logic              mem_we,
  input logic [31:0]       mem_wdata,
  input logic              tx_go,
  input logic              tx_reload,
  input logic              tx_wr_any,
  input logic [2:0]        cur_step,
  input logic [ADDR_W-1:0] tx_ptr,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  tx_ncnt,
  input logic              tx_end,
  input logic              tx_empty,
  input logic              rx_end,
  input logic              rx_full
);
  assert_tx_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_tx_load |-> (mem_req && !mem_we));

  assert_rx_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_rx_take |-> (mem_req && mem_we));

  assert_rx_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_tx_load && spi_rx_take));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '0) |-> !spi_tx_load);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go && !tx_reload && !tx_wr_any) |=>
      (tx_ptr == $past(tx_ptr) + ADDR_W'($past(cur_step))) &&
      (tx_cnt == $past(tx_cnt) - CNT_W'(1)));

  assert_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reload |=> (tx_ncnt == '0) && (tx_cnt != '0));

  assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty |-> tx_end) and (rx_full |-> rx_end));

  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_rx_take && !cfg_var_mode) |-> (mem_wdata[31:16] == 16'h0));
endmodule

bind spi_buf_seq spi_buf_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_var_mode(cfg_var_mode),
  .spi_tx_load (spi_tx_load),
  .spi_rx_take (spi_rx_take),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_wdata   (mem_wdata),
  .tx_go       (tx_go),
  .tx_reload   (tx_reload),
  .tx_wr_any   (tx_wr_any),
  .cur_step    (cur_step),
  .tx_ptr      (tx_ptr),
  .tx_cnt      (tx_cnt),
  .tx_ncnt     (tx_ncnt),
  .tx_end      (tx_end),
  .tx_empty    (tx_empty),
  .rx_end      (rx_end),
  .rx_full     (rx_full)
);

// File: tb/sim_spi_buf_seq.sv
`timescale 1ns/1ps
module sim_spi_buf_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_var_mode = 1'b0;
  logic [4:0]  cfg_char_bits = 5'd8;
  logic [7:0]  cfg_fixed_cs = 8'h5A;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        spi_tx_empty = 1'b0;
  logic        spi_tx_load;
  logic [15:0] spi_tx_data;
  logic [7:0]  spi_tx_cs;
  logic        spi_tx_last;
  logic        spi_rx_ready = 1'b0;
  logic [15:0] spi_rx_data = 16'h0;
  logic [7:0]  spi_rx_cs = 8'h0;
  logic        spi_rx_take;
  logic        mem_req, mem_we;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_end, tx_empty, rx_end, rx_full;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  spi_buf_seq u0 (.*);

  // Byte-addressed little-endian memory, right-justified data.
  always_comb begin
    logic [7:0] a;
    a = mem_addr[7:0];
    case (mem_size)
      2'd0:    mem_rdata = {24'h0, mem[a]};
      2'd1:    mem_rdata = {16'h0, mem[8'(a + 1)], mem[a]};
      default: mem_rdata = {mem[8'(a + 3)], mem[8'(a + 2)], mem[8'(a + 1)], mem[a]};
    endcase
  end

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_size != 2'd0) mem[8'(mem_addr[7:0] + 1)] <= mem_wdata[15:8];
      if (mem_size == 2'd2) begin
        mem[8'(mem_addr[7:0] + 2)] <= mem_wdata[23:16];
        mem[8'(mem_addr[7:0] + 3)] <= mem_wdata[31:24];
      end
    end
  end

  function automatic logic [7:0] seed(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] sel, output logic [31:0] val);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic tx_one(input string req, input logic [31:0] addr, input logic [1:0] size,
                        input logic [15:0] data, input logic [7:0] cs, input logic last);
    @(negedge clk);
    spi_tx_empty = 1'b1;
    #1;
    chk({req, " load"}, {31'h0, spi_tx_load}, 32'h1);
    chk({req, " read"}, {30'h0, mem_req, mem_we}, 32'h2);
    chk({req, " addr"}, mem_addr, addr);
    chk({req, " size"}, {30'h0, mem_size}, {30'h0, size});
    chk({req, " data"}, {16'h0, spi_tx_data}, {16'h0, data});
    chk({req, " cs"}, {24'h0, spi_tx_cs}, {24'h0, cs});
    chk({req, " last"}, {31'h0, spi_tx_last}, {31'h0, last});
    @(negedge clk);
    spi_tx_empty = 1'b0;
  endtask

  task automatic rx_one(input string req, input logic [15:0] d, input logic [7:0] cs,
                        input logic [31:0] addr, input logic [1:0] size, input logic [31:0] word);
    @(negedge clk);
    spi_rx_ready = 1'b1; spi_rx_data = d; spi_rx_cs = cs;
    #1;
    chk({req, " take"}, {31'h0, spi_rx_take}, 32'h1);
    chk({req, " write"}, {30'h0, mem_req, mem_we}, 32'h3);
    chk({req, " addr"}, mem_addr, addr);
    chk({req, " size"}, {30'h0, mem_size}, {30'h0, size});
    chk({req, " wdata"}, mem_wdata, word);
    @(negedge clk);
    spi_rx_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int s = 0; s < 8; s++) begin
      rreg(3'(s), v);
      chk("R1 reg zero", v, 32'h0);
    end
    chk("R1 flags", {28'h0, tx_end, tx_empty, rx_end, rx_full}, 32'hF);
    @(negedge clk);
    spi_tx_empty = 1'b1; spi_rx_ready = 1'b1;
    #1;
    chk("R11 idle no access", {29'h0, mem_req, spi_tx_load, spi_rx_take}, 32'h0);
    @(negedge clk);
    spi_tx_empty = 1'b0; spi_rx_ready = 1'b0;
  endtask

  task automatic t_fixed8;
    logic [31:0] v;
    cfg_var_mode = 1'b0; cfg_char_bits = 5'd8;
    wreg(3'd0, 32'h10); wreg(3'd1, 32'd3);
    chk("R7 end low", {31'h0, tx_end}, 32'h0);
    for (int k = 0; k < 3; k++)
      tx_one("R3 fixed8", 32'h10 + k, 2'd0, {8'h0, seed(16 + k)}, 8'h5A, 1'b0);
    rreg(3'd0, v); chk("R3 ptr", v, 32'h13);
    rreg(3'd1, v); chk("R3 cnt", v, 32'h0);
    chk("R7 tx flags", {30'h0, tx_end, tx_empty}, 32'h3);
  endtask

  task automatic t_fixed12;
    logic [31:0] v;
    cfg_var_mode = 1'b0; cfg_char_bits = 5'd12;
    wreg(3'd0, 32'h40); wreg(3'd1, 32'd2);
    for (int k = 0; k < 2; k++)
      tx_one("R4 fixed12", 32'h40 + 2 * k, 2'd1,
             {seed(65 + 2 * k), seed(64 + 2 * k)} & 16'h0FFF, 8'h5A, 1'b0);
    rreg(3'd0, v); chk("R4 ptr", v, 32'h44);
  endtask

  task automatic t_var;
    logic [31:0] v;
    {mem[8'h83], mem[8'h82], mem[8'h81], mem[8'h80]} = 32'h0103_A5C7;
    {mem[8'h87], mem[8'h86], mem[8'h85], mem[8'h84]} = 32'h0005_1234;
    cfg_var_mode = 1'b1; cfg_char_bits = 5'd10;
    wreg(3'd0, 32'h80); wreg(3'd1, 32'd2);
    tx_one("R6 var word0", 32'h80, 2'd2, 16'h01C7, 8'h03, 1'b1);
    tx_one("R6 var word1", 32'h84, 2'd2, 16'h0234, 8'h05, 1'b0);
    rreg(3'd0, v); chk("R5 ptr", v, 32'h88);
    rreg(3'd1, v); chk("R5 cnt", v, 32'h0);
    cfg_var_mode = 1'b0;
  endtask

  task automatic t_rx;
    logic [31:0] v;
    cfg_var_mode = 1'b0; cfg_char_bits = 5'd9;
    wreg(3'd4, 32'hA0); wreg(3'd5, 32'd2);
    chk("R7 rx end low", {31'h0, rx_end}, 32'h0);
    rx_one("R4 rx fill", 16'hFFFF, 8'hEE, 32'hA0, 2'd1, 32'h0000_01FF);
    rx_one("R4 rx next", 16'h0123, 8'hEE, 32'hA2, 2'd1, 32'h0000_0123);
    @(negedge clk);
    chk("R4 rx mem lo", {24'h0, mem[8'hA0]}, 32'hFF);
    chk("R4 rx mem hi", {24'h0, mem[8'hA1]}, 32'h01);
    rreg(3'd4, v); chk("R4 rx ptr", v, 32'hA4);
    chk("R7 rx flags", {30'h0, rx_end, rx_full}, 32'h3);
    cfg_var_mode = 1'b1; cfg_char_bits = 5'd16;
    wreg(3'd4, 32'hC0); wreg(3'd5, 32'd1);
    rx_one("R6 rx var", 16'hBEEF, 8'h0A, 32'hC0, 2'd2, 32'h000A_BEEF);
    rreg(3'd4, v); chk("R5 rx ptr", v, 32'hC4);
    cfg_var_mode = 1'b0;
  endtask

  task automatic t_chain;
    logic [31:0] v;
    cfg_char_bits = 5'd8;
    wreg(3'd0, 32'h20); wreg(3'd1, 32'd1);
    wreg(3'd2, 32'h30); wreg(3'd3, 32'd2);
    chk("R7 chain flags", {30'h0, tx_end, tx_empty}, 32'h0);
    tx_one("R8 before", 32'h20, 2'd0, {8'h0, seed(32)}, 8'h5A, 1'b0);
    rreg(3'd0, v); chk("R8 ptr loaded", v, 32'h30);
    rreg(3'd1, v); chk("R8 cnt loaded", v, 32'd2);
    rreg(3'd3, v); chk("R8 next cleared", v, 32'd0);
    chk("R8 end stays low", {31'h0, tx_end}, 32'h0);
    tx_one("R8 after0", 32'h30, 2'd0, {8'h0, seed(48)}, 8'h5A, 1'b0);
    tx_one("R8 after1", 32'h31, 2'd0, {8'h0, seed(49)}, 8'h5A, 1'b0);
    chk("R7 chain done", {30'h0, tx_end, tx_empty}, 32'h3);
    wreg(3'd2, 32'h50); wreg(3'd3, 32'd1);
    @(negedge clk);
    rreg(3'd0, v); chk("R8 idle load ptr", v, 32'h50);
    rreg(3'd1, v); chk("R8 idle load cnt", v, 32'd1);
    wreg(3'd1, 32'd0);
  endtask

  task automatic t_prio;
    wreg(3'd0, 32'h10); wreg(3'd1, 32'd1);
    wreg(3'd4, 32'hE0); wreg(3'd5, 32'd1);
    @(negedge clk);
    spi_tx_empty = 1'b1; spi_rx_ready = 1'b1; spi_rx_data = 16'h0042;
    #1;
    chk("R9 rx first", {30'h0, spi_rx_take, spi_tx_load}, 32'h2);
    chk("R9 rx addr", mem_addr, 32'hE0);
    @(negedge clk);
    spi_rx_ready = 1'b0;
    #1;
    chk("R9 tx later", {30'h0, spi_rx_take, spi_tx_load}, 32'h1);
    chk("R9 tx addr", mem_addr, 32'h10);
    @(negedge clk);
    spi_tx_empty = 1'b0;
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wreg(3'd0, 32'h60); wreg(3'd1, 32'd2);
    wreg(3'd1, 32'd0);
    @(negedge clk);
    spi_tx_empty = 1'b1;
    #1 chk("R11 disabled", {30'h0, mem_req, spi_tx_load}, 32'h0);
    @(negedge clk);
    spi_tx_empty = 1'b0;
    wreg(3'd1, 32'd5);
    @(negedge clk);
    spi_tx_empty = 1'b1; reg_wr = 1'b1; reg_sel = 3'd1; reg_wdata = 32'd9;
    @(negedge clk);
    spi_tx_empty = 1'b0; reg_wr = 1'b0;
    rreg(3'd1, v); chk("R10 write wins", v, 32'd9);
    rreg(3'd0, v); chk("R10 ptr moved", v, 32'h61);
    rreg(3'd5, v); chk("R9 rx untouched", v, 32'd0);
    wreg(3'd1, 32'd0);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = seed(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed8();
    t_fixed12();
    t_var();
    t_rx();
    t_chain();
    t_prio();
    t_regs();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule